// File: doc/BRIEF.md
# Shadow RAM Region Attribute Decoder

This block holds the configuration that decides, for the upper-memory window of a PC-style address map, where each CPU access goes. The window runs from 0xA0000 up to 0xFFFFF and is cut into 24 segments of 16 KB each. For every segment the block works out two routing attributes, one for reads and one for writes. Each attribute says whether the access is served by internal (shadow) RAM, passed to the external bus, or dropped.

Three kinds of setting feed the decision. A shadow-enable bit exists for each segment. A ROM-enable bit and a write-protect bit each cover 32 KB of the range from 0xC0000 upward. Two per-segment input vectors tell the block whether an external ROM device claims the segment. The read path and the write path each have their own vector. A ROM-claimed segment whose ROM-enable bit is clear is cut off rather than sent outside.

A translation unit presents an address on the lookup port and gets both routes back in the same cycle. Register writes go through a simple select/data/strobe port. Any write that is accepted raises a one-cycle invalidate pulse, so that cached translations built from the old settings can be flushed.

Top module: `shadow_attr_decoder`

## Requirements
- R1: After reset all shadow-enable, ROM-enable and write-protect bits are 0 and `inval` is low.
- R2: Address A in [0xA0000, 0xFFFFF] belongs to segment i = (A − 0xA0000) >> 14. The shadow-enable bit for segment i is bit i%8 of the shadow register with select code i/8. Select codes 0, 1 and 2 are the shadow registers, code 3 is ROM enable and code 4 is write protect.
- R3: The read route is internal whenever the segment's shadow bit is set.
- R4: With the shadow bit clear, the read route is external if `romcs_rd[i]` is 0. It is also external if `romcs_rd[i]` is 1 and the segment's ROM-enable bit is 1. Otherwise the read route is disabled.
- R5: A set write-protect bit makes the write route disabled, whatever the shadow bit says.
- R6: Without write protect, the write route is internal if the shadow bit is set. Otherwise it follows the rule of R4, using `romcs_wr[i]` in place of `romcs_rd[i]`.
- R7: For a segment at or above 0xC0000, the ROM-enable and write-protect bit index is (A − 0xC0000) >> 15. For segments from 0xA0000 to 0xBFFFF, both registers are ignored and treated as 0.
- R8: Route encoding: 2'b00 means disabled, 2'b01 means external and 2'b10 means internal. The value 2'b11 never appears.
- R9: A write strobe with select code 0 to 4 sets `inval` high for exactly the next cycle. In every other cycle `inval` is low.
- R10: An address outside [0xA0000, 0xFFFFF] returns external for both routes.
- R11: A write with select code 5, 6 or 7 changes no setting and raises no `inval`.
- R12: The lookup is combinational in the address and the ROM-claim inputs. A register write becomes visible in the cycle after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 8 | Register write data |
| romcs_rd | input | 24 | Per-segment flag: an external ROM claims reads of the segment |
| romcs_wr | input | 24 | Per-segment flag: an external ROM claims writes to the segment |
| lk_addr | input | 24 | Lookup address |
| lk_rd_route | output | 2 | Read route for lk_addr |
| lk_wr_route | output | 2 | Write route for lk_addr |
| inval | output | 1 | One-cycle pulse after an accepted register write |

## Verification
The bench probes the first and last byte of every segment. A wrong segment or bit split shows up at these edges: the address would pick up a neighbour's shadow bit, or the 32 KB ROM-enable and write-protect bits would land on the wrong pair of segments. The read and write ROM-claim inputs are driven with different values so that the two paths can be told apart. A design that shared one claim flag between them would route writes by the read rule. Write protect is applied together with shadow enable, so a design that let shadow win would return internal writes. Set ROM-enable and write-protect bits are paired with probes below 0xC0000, which would expose a design that decodes them there. The bench also writes the unused select codes, which would catch a design that changes a setting or pulses invalidate for them, and it probes addresses just outside the window.

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder #(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 8,
  parameter int SEL_W      = 3,
  parameter int SEG_CNT    = 24,
  parameter int SEG_SHIFT  = 14,
  parameter int PROT_SHIFT = 15,
  parameter int WIN_BASE   = 'h0A0000,
  parameter int ROM_BASE   = 'h0C0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [SEG_CNT-1:0] romcs_rd,
  input  logic [SEG_CNT-1:0] romcs_wr,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic [1:0]        lk_rd_route,
  output logic [1:0]        lk_wr_route,
  output logic              inval
);
  localparam int SH_REGS   = (SEG_CNT + DATA_W - 1) / DATA_W;
  localparam int SEL_ROM   = SH_REGS;
  localparam int SEL_WP    = SH_REGS + 1;
  localparam int SEG_W     = $clog2(SEG_CNT);
  localparam int WIN_END   = WIN_BASE + (SEG_CNT << SEG_SHIFT);
  localparam int PROT_BITS = (WIN_END - ROM_BASE) >> PROT_SHIFT;
  localparam logic [ADDR_W:0] LO_X = (ADDR_W+1)'(WIN_BASE);
  localparam logic [ADDR_W:0] HI_X = (ADDR_W+1)'(WIN_END);
  localparam logic [1:0] RT_OFF = 2'b00;
  localparam logic [1:0] RT_EXT = 2'b01;
  localparam logic [1:0] RT_INT = 2'b10;

  logic [SH_REGS*DATA_W-1:0] shadow_q;
  logic [PROT_BITS-1:0]      romen_q;
  logic [PROT_BITS-1:0]      wprot_q;
  logic                      inval_q;
  logic [1:0]                seg_rd [SEG_CNT];
  logic [1:0]                seg_wr [SEG_CNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      romen_q  <= '0;
      wprot_q  <= '0;
      inval_q  <= 1'b0;
    end else begin
      inval_q <= cfg_we && (cfg_sel <= SEL_W'(SEL_WP));
      if (cfg_we) begin
        for (int r = 0; r < SH_REGS; r++)
          if (cfg_sel == SEL_W'(r)) shadow_q[r*DATA_W +: DATA_W] <= cfg_wdata;
        if (cfg_sel == SEL_W'(SEL_ROM)) romen_q <= cfg_wdata[PROT_BITS-1:0];
        if (cfg_sel == SEL_W'(SEL_WP))  wprot_q <= cfg_wdata[PROT_BITS-1:0];
      end
    end
  end

  for (genvar g = 0; g < SEG_CNT; g++) begin : g_seg
    localparam int SB = WIN_BASE + (g << SEG_SHIFT);
    logic rom_ok, wp;
    if (SB >= ROM_BASE) begin : g_hi
      localparam int PB = (SB - ROM_BASE) >> PROT_SHIFT;
      assign rom_ok = romen_q[PB];
      assign wp     = wprot_q[PB];
    end else begin : g_lo
      assign rom_ok = 1'b0;
      assign wp     = 1'b0;
    end
    wire ext_rd = !romcs_rd[g] || rom_ok;
    wire ext_wr = !romcs_wr[g] || rom_ok;
    assign seg_rd[g] = shadow_q[g] ? RT_INT : (ext_rd ? RT_EXT : RT_OFF);
    assign seg_wr[g] = wp ? RT_OFF : (shadow_q[g] ? RT_INT : (ext_wr ? RT_EXT : RT_OFF));
  end

  wire [ADDR_W:0]   addr_x  = {1'b0, lk_addr};
  wire              in_win  = (addr_x >= LO_X) && (addr_x < HI_X);
  wire [ADDR_W-1:0] off     = lk_addr - ADDR_W'(WIN_BASE);
  wire [SEG_W-1:0]  seg_idx = SEG_W'(off >> SEG_SHIFT);

  assign lk_rd_route = in_win ? seg_rd[seg_idx] : RT_EXT;
  assign lk_wr_route = in_win ? seg_wr[seg_idx] : RT_EXT;
  assign inval       = inval_q;
endmodule

// File: rtl/shadow_attr_decoder_chk.sv
module shadow_attr_decoder_chk #(
  parameter int ADDR_W    = 24,
  parameter int SEL_W     = 3,
  parameter int SEG_CNT   = 24,
  parameter int SEG_SHIFT = 14,
  parameter int WIN_BASE  = 'h0A0000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [SEL_W-1:0]   cfg_sel,
  input logic [SEG_CNT-1:0] romcs_rd,
  input logic [SEG_CNT-1:0] romcs_wr,
  input logic [ADDR_W-1:0]  lk_addr,
  input logic [1:0]         lk_rd_route,
  input logic [1:0]         lk_wr_route,
  input logic               inval
);
  localparam int LAST_SEL = (SEG_CNT + 7) / 8 + 1;
  localparam logic [ADDR_W:0] LO_X = (ADDR_W+1)'(WIN_BASE);
  localparam logic [ADDR_W:0] HI_X = (ADDR_W+1)'(WIN_BASE + (SEG_CNT << SEG_SHIFT));
  wire outside = ({1'b0, lk_addr} < LO_X) || ({1'b0, lk_addr} >= HI_X);
  wire accept  = cfg_we && (cfg_sel <= SEL_W'(LAST_SEL));

  // R8
  route_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_rd_route != 2'b11) && (lk_wr_route != 2'b11));
  // R9
  inval_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> inval);
  // R9 R11
  inval_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !inval);
  // R10
  outside_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outside |-> (lk_rd_route == 2'b01) && (lk_wr_route == 2'b01));
  // R3 R6
  rd_off_no_wr_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_rd_route == 2'b00) |-> (lk_wr_route != 2'b10));
  // R12
  hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(lk_addr) && $stable(romcs_rd) && $stable(romcs_wr) && !$past(cfg_we))
      |-> ($stable(lk_rd_route) && $stable(lk_wr_route)));
endmodule

bind shadow_attr_decoder shadow_attr_decoder_chk #(
  .ADDR_W(ADDR_W), .SEL_W(SEL_W), .SEG_CNT(SEG_CNT),
  .SEG_SHIFT(SEG_SHIFT), .WIN_BASE(WIN_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .romcs_rd(romcs_rd), .romcs_wr(romcs_wr), .lk_addr(lk_addr),
  .lk_rd_route(lk_rd_route), .lk_wr_route(lk_wr_route), .inval(inval)
);

// File: tb/shadow_attr_decoder_tb.sv
module shadow_attr_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [23:0] romcs_rd = '0;
  logic [23:0] romcs_wr = '0;
  logic [23:0] lk_addr = '0;
  logic [1:0]  lk_rd_route, lk_wr_route;
  logic        inval;

  shadow_attr_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .romcs_rd(romcs_rd), .romcs_wr(romcs_wr),
    .lk_addr(lk_addr), .lk_rd_route(lk_rd_route), .lk_wr_route(lk_wr_route),
    .inval(inval)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    tests = 0, fails = 0, cycles = 0;
  bit    done = 0;
  string phase = "R1";

  // reference state
  int m_sh [3];
  int m_rom = 0, m_wp = 0;
  bit m_inval = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sh[0] <= 0; m_sh[1] <= 0; m_sh[2] <= 0;
      m_rom <= 0; m_wp <= 0; m_inval <= 0;
    end else begin
      m_inval <= cfg_we && (cfg_sel <= 4);
      if (cfg_we) begin
        case (cfg_sel)
          0, 1, 2: m_sh[cfg_sel] <= cfg_wdata;
          3: m_rom <= cfg_wdata;
          4: m_wp  <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  // 0 disabled, 1 external, 2 internal
  function automatic int ref_route(int a, bit is_wr, logic [23:0] crd, logic [23:0] cwr);
    int seg, sh, ren, wp, k;
    bit claim;
    if (a < 'hA0000 || a > 'hFFFFF) return 1;
    seg = (a - 'hA0000) / 'h4000;
    sh  = (m_sh[seg / 8] >> (seg % 8)) & 1;
    ren = 0; wp = 0;
    if (a >= 'hC0000) begin
      k = (a - 'hC0000) / 'h8000;
      ren = (m_rom >> k) & 1;
      wp  = (m_wp >> k) & 1;
    end
    claim = is_wr ? cwr[seg] : crd[seg];
    if (is_wr && wp) return 0;
    if (sh) return 2;
    if (!claim || ren) return 1;
    return 0;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (addr %h)", req, what, act, exp, lk_addr);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(phase, "read route", lk_rd_route, ref_route(lk_addr, 0, romcs_rd, romcs_wr));
      check(phase, "write route", lk_wr_route, ref_route(lk_addr, 1, romcs_rd, romcs_wr));
      check(phase, "inval", inval, m_inval);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr_reg(int sel, int data);
    @(posedge clk); #1;
    cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = 8'(data);
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic probe(int a, logic [23:0] crd, logic [23:0] cwr);
    @(posedge clk); #1;
    lk_addr = 24'(a); romcs_rd = crd; romcs_wr = cwr;
  endtask

  task automatic sweep(logic [23:0] crd, logic [23:0] cwr);
    for (int s = 0; s < 24; s++) begin
      probe('hA0000 + s * 'h4000, crd, cwr);
      probe('hA0000 + s * 'h4000 + 'h3FFF, crd, cwr);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state, explicit samples
    @(negedge clk);
    tests++; if (inval !== 1'b0) begin fails++; $display("FAIL R1 inval: actual %0d expected 0", inval); end
    tests++; if (lk_rd_route !== 2'b01) begin fails++; $display("FAIL R1 read route: actual %0d expected 1", lk_rd_route); end
    phase = "R1";
    probe('hF0000, '1, '0);
    sweep('1, '1);
    // R2 R3: walk a single shadow bit through each register
    phase = "R2 R3";
    for (int r = 0; r < 3; r++) begin
      for (int b = 0; b < 8; b += 3) begin
        wr_reg(r, 1 << b);
        sweep(24'h5A5A5A, 24'hA5A5A5);
      end
      wr_reg(r, 0);
    end
    // R4 R7: ROM enable with claims on read path only
    phase = "R4 R7";
    wr_reg(3, 'h5A);
    sweep('1, '0);
    sweep(24'h0F0F0F, 24'hF0F0F0);
    wr_reg(3, 'hFF);
    sweep('1, '1);
    // R5 R6: write protect over shadow, separate write claims
    phase = "R5 R6";
    wr_reg(3, 'h0F);
    wr_reg(0, 'hFF); wr_reg(1, 'h0F); wr_reg(2, 'hC3);
    wr_reg(4, 'hA5);
    sweep(24'h123456, 24'hFEDCBA);
    wr_reg(4, 0);
    sweep('0, '1);
    // R7: low segments ignore ROM enable and write protect
    phase = "R7";
    wr_reg(0, 0); wr_reg(1, 0); wr_reg(2, 0);
    wr_reg(3, 'hFF); wr_reg(4, 'hFF);
    for (int a = 'hA0000; a < 'hC0000; a += 'h2000) probe(a, '1, '0);
    // R10: outside the window
    phase = "R10";
    probe('h9FFFF, '1, '1); probe('h000000, '1, '1);
    probe('h100000, '1, '1); probe('hFFFFFF, '1, '1);
    probe('hA0000, '1, '1); probe('hFFFFF, '0, '1);
    // R11: unused select codes
    phase = "R11";
    wr_reg(4, 0); wr_reg(3, 0);
    for (int s = 5; s < 8; s++) begin
      wr_reg(s, 'hFF);
      sweep('1, '0);
    end
    // R9 R12: back-to-back writes and random traffic
    phase = "R9 R12";
    @(posedge clk); #1 cfg_we = 1; cfg_sel = 0; cfg_wdata = 'h01; lk_addr = 'hA0000;
    @(posedge clk); #1 cfg_sel = 4; cfg_wdata = 'h00;
    @(posedge clk); #1 cfg_sel = 6;
    @(posedge clk); #1 cfg_we = 0;
    repeat (2000) begin
      @(posedge clk); #1;
      cfg_we    = ($urandom % 4) == 0;
      cfg_sel   = 3'($urandom);
      cfg_wdata = 8'($urandom);
      romcs_rd  = 24'($urandom);
      romcs_wr  = 24'($urandom);
      lk_addr   = ($urandom % 8 == 0) ? 24'($urandom) : 24'('h98000 + $urandom % 'h6C000);
    end
    @(posedge clk); #1 cfg_we = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule